// File: doc/BRIEF.md
# Tagged Half-Word Load/Store Unit

This unit moves data between 16-bit registers and a local memory of 2048 words of 32 bits. A store can fill the low half of a word, the high half, or the whole word. When it fills the whole word, the word carries the writer's program counter and a 2-bit user label next to the data. A load returns one half of a word.

The unit keeps its own word offset register, which a set-offset operation loads. Two auto-increment stores use this register. The half-word form writes the low half first and the high half on its next use, then moves to the next word. The full-word form moves to the next word after every store.

Each accepted operation keeps the unit busy for four cycles. The memory is driven with one strobe in the first of those cycles. The memory is synchronous: read data is valid in the cycle after the strobe.

Top module: `halfword_lsu`

## Requirements
- R1: The effective word address is (base_addr + floor(offset / 4)) mod 2048, where offset is the signed byte offset. Direct stores (op 0, 1, 2) take the offset from byte_ofs[10:0], sign bit 10, and ignore byte_ofs[12:11]. Loads (op 6, 7) take it from byte_ofs[12:0], sign bit 12. Bits of base_addr above bit 10 have no effect.
- R2: Op 0 stores a half-word into bits 15:0 with mem_be = 4'b0011. Op 1 stores it into bits 31:16 with mem_be = 4'b1100. The other half of the word is left unchanged.
- R3: The stored half-word is {label, src_data[13:0]} when label_en is 1, and src_data[15:0] when label_en is 0.
- R4: Op 2 writes the whole word {pc[10:0], 3'b000, label[1:0], src_data[15:0]} with mem_be = 4'b1111, whatever the value of label_en.
- R5: Op 3 loads the offset register with floor(byte_ofs[10:0] / 4), read as signed. It clears the half-select phase and makes no memory access.
- R6: Op 4 stores a half-word (formed as in R3) at base_addr + offset register. With the phase clear, it writes the low half and sets the phase. With the phase set, it writes the high half at the same address, clears the phase and adds one to the offset register.
- R7: Op 5 writes a full word (formed as in R4) at base_addr + offset register. It then adds one to the offset register and clears the half-select phase.
- R8: Op 6 returns bits 15:0 of the addressed word on ld_data, and op 7 returns bits 31:16. ld_valid is high for exactly one cycle, the fourth busy cycle, and ld_data holds its value afterwards.
- R9: An operation is accepted when op_valid is high and busy is low. busy is then high for exactly four cycles, and mem_en pulses once, in the first of them. Requests made while busy is high are ignored.
- R10: After reset, busy, mem_en, ld_valid and ld_data are zero, the offset register is zero and the phase is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Request an operation |
| op | input | 3 | Operation code (see R2 to R8) |
| src_data | input | 16 | Data register value for stores |
| base_addr | input | 16 | Base word address register |
| byte_ofs | input | 13 | Signed byte offset operand |
| label | input | 2 | User label |
| label_en | input | 1 | Label supplied for half-word stores |
| pc | input | 11 | Program counter of the operation |
| mem_rdata | input | 32 | Memory read data, valid the cycle after the strobe |
| busy | output | 1 | Operation in progress |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Write qualifier for the strobe |
| mem_addr | output | 11 | Memory word address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Write data |
| ld_data | output | 16 | Loaded half-word |
| ld_valid | output | 1 | Load result valid |

## Verification
The bench sweeps base and offset values across their signed ranges, including wraps past word 2047 and below word 0. A design that shifts the offset logically instead of arithmetically, or that reads the wrong sign bit, would store to or load from the wrong word. Half stores are checked against words preloaded with a known pattern, so a byte enable that disturbs the other half shows up at once. The auto-increment sequences are run in order: low half, high half, next word, and a set-offset issued in the middle of a pair. A phase that is not cleared would write the high half of a fresh word, and an offset that advances on the low half would split a pair across two words. A request made while the unit is busy must leave memory untouched; a design that took it would show a second strobe.

// File: rtl/halfword_lsu.sv
module halfword_lsu #(
  parameter int AW   = 11,
  parameter int DW   = 16,
  parameter int PCW  = 11,
  parameter int LW   = 2,
  parameter int SOFW = 11,
  parameter int LOFW = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [2:0]      op,
  input  logic [DW-1:0]   src_data,
  input  logic [15:0]     base_addr,
  input  logic [LOFW-1:0] byte_ofs,
  input  logic [LW-1:0]   label,
  input  logic            label_en,
  input  logic [PCW-1:0]  pc,
  input  logic [2*DW-1:0] mem_rdata,
  output logic            busy,
  output logic            mem_en,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [3:0]      mem_be,
  output logic [2*DW-1:0] mem_wdata,
  output logic [DW-1:0]   ld_data,
  output logic            ld_valid
);
  localparam int WW   = 2 * DW;
  localparam int PADW = WW - PCW - LW - DW;
  localparam logic [2:0] OP_STL  = 3'd0;
  localparam logic [2:0] OP_STH  = 3'd1;
  localparam logic [2:0] OP_STW  = 3'd2;
  localparam logic [2:0] OP_SETO = 3'd3;
  localparam logic [2:0] OP_STIH = 3'd4;
  localparam logic [2:0] OP_STIW = 3'd5;
  localparam logic [2:0] OP_LDL  = 3'd6;
  localparam logic [2:0] OP_LDH  = 3'd7;

  logic [AW-1:0] ofs_q;
  logic          tog_q;
  logic          busy_q;
  logic [1:0]    cnt_q;
  logic          acc_q, we_q, hi_q;
  logic [AW-1:0] addr_q;
  logic [3:0]    be_q;
  logic [WW-1:0] wd_q;

  wire accept = op_valid && !busy_q;
  wire [AW-1:0] base_w = base_addr[AW-1:0];
  wire [AW-1:0] sofs_w = AW'($signed(byte_ofs[SOFW-1:2]));
  wire [AW-1:0] lofs_w = AW'($signed(byte_ofs[LOFW-1:2]));
  wire [DW-1:0] half_v = label_en ? {label, src_data[DW-LW-1:0]} : src_data;
  wire [WW-1:0] full_v = {pc, {PADW{1'b0}}, label, src_data};

  logic [AW-1:0] n_addr;
  logic [3:0]    n_be;
  logic [WW-1:0] n_wd;
  logic          n_we, n_acc;

  always_comb begin
    n_addr = base_w + sofs_w;
    n_be   = 4'b0000;
    n_wd   = {half_v, half_v};
    n_we   = 1'b1;
    n_acc  = 1'b1;
    case (op)
      OP_STL:  n_be = 4'b0011;
      OP_STH:  n_be = 4'b1100;
      OP_STW:  begin n_be = 4'b1111; n_wd = full_v; end
      OP_SETO: begin n_we = 1'b0; n_acc = 1'b0; end
      OP_STIH: begin
        n_addr = base_w + ofs_q;
        n_be   = tog_q ? 4'b1100 : 4'b0011;
      end
      OP_STIW: begin
        n_addr = base_w + ofs_q;
        n_be   = 4'b1111;
        n_wd   = full_v;
      end
      default: begin
        n_addr = base_w + lofs_w;
        n_we   = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      acc_q  <= 1'b0;
      we_q   <= 1'b0;
      hi_q   <= 1'b0;
      addr_q <= '0;
      be_q   <= '0;
      wd_q   <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      acc_q  <= n_acc;
      we_q   <= n_we;
      hi_q   <= (op == OP_LDH);
      addr_q <= n_addr;
      be_q   <= n_be;
      wd_q   <= n_wd;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 2'd1;
      if (cnt_q == 2'd3) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q <= '0;
      tog_q <= 1'b0;
    end else if (accept) begin
      case (op)
        OP_SETO: begin ofs_q <= sofs_w; tog_q <= 1'b0; end
        OP_STIH: begin
          tog_q <= !tog_q;
          if (tog_q) ofs_q <= ofs_q + AW'(1);
        end
        OP_STIW: begin ofs_q <= ofs_q + AW'(1); tog_q <= 1'b0; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ld_data <= '0;
    else if (busy_q && cnt_q == 2'd1 && acc_q && !we_q)
      ld_data <= hi_q ? mem_rdata[WW-1:DW] : mem_rdata[DW-1:0];
  end

  assign busy      = busy_q;
  assign mem_en    = busy_q && cnt_q == 2'd0 && acc_q;
  assign mem_we    = mem_en && we_q;
  assign mem_addr  = addr_q;
  assign mem_be    = be_q;
  assign mem_wdata = wd_q;
  assign ld_valid  = busy_q && cnt_q == 2'd3 && acc_q && !we_q;

  // R9
  accept_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op != OP_SETO) |=> mem_en);
  // R9
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |=> !mem_en);
  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy ##1 busy ##1 busy ##1 !busy);
  // R2
  be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_be == 4'b0011 || mem_be == 4'b1100 || mem_be == 4'b1111));
  // R5
  seto_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_SETO) |=> !tog_q && !mem_en);
  // R6
  auto_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_STIH && tog_q) |=> (ofs_q == $past(ofs_q) + AW'(1)) && !tog_q);
  // R8
  ldv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> !ld_valid && $stable(ld_data));
endmodule

// File: tb/halfword_lsu_tb.sv
module halfword_lsu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [15:0] src_data = '0;
  logic [15:0] base_addr = '0;
  logic [12:0] byte_ofs = '0;
  logic [1:0]  label = '0;
  logic        label_en = 1'b0;
  logic [10:0] pc = '0;
  logic [31:0] mem_rdata = '0;
  logic        busy, mem_en, mem_we, ld_valid;
  logic [10:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic [15:0] ld_data;

  halfword_lsu u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op), .src_data(src_data),
    .base_addr(base_addr), .byte_ofs(byte_ofs), .label(label), .label_en(label_en),
    .pc(pc), .mem_rdata(mem_rdata), .busy(busy), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .ld_data(ld_data), .ld_valid(ld_valid)
  );

  always #5 clk = ~clk;

  logic [31:0] mem [0:2047];
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr][8*b +: 8] = mem_wdata[8*b +: 8];
      end else mem_rdata <= mem[mem_addr];
    end
  end

  int checks = 0;
  int errors = 0;
  int last_cycles, last_strobes, last_lv;
  logic [10:0] last_addr;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic run_op(input logic [2:0] o, input logic [15:0] d, input logic [15:0] b,
                        input logic [12:0] ofs, input logic [1:0] lb, input logic le,
                        input logic [10:0] p, input bit poke);
    @(negedge clk);
    op = o; src_data = d; base_addr = b; byte_ofs = ofs; label = lb; label_en = le; pc = p;
    op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    last_cycles = 0; last_strobes = 0; last_lv = 0;
    while (busy && last_cycles < 10) begin
      if (mem_en) begin last_strobes++; last_addr = mem_addr; end
      if (ld_valid) last_lv++;
      if (poke && last_cycles == 1) begin
        op = 3'd0; src_data = 16'hFFFF; base_addr = 16'd500; byte_ofs = '0;
        label_en = 1'b0; op_valid = 1'b1;
      end else op_valid = 1'b0;
      last_cycles++;
      @(negedge clk);
    end
    op_valid = 1'b0;
  endtask

  function automatic logic [15:0] hv(input logic [15:0] d, input logic [1:0] lb, input logic le);
    return le ? {lb, d[13:0]} : d;
  endfunction

  function automatic logic [10:0] eaddr(input logic [15:0] b, input int so);
    int s;
    s = so >>> 2;
    return 11'((int'(b) + s) & 2047);
  endfunction

  bit done = 0;
  initial begin
    #(10 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] old, expw;
    logic [15:0] b, d;
    logic [12:0] ofs;
    logic [10:0] ea;
    int so;
    for (int i = 0; i < 2048; i++) mem[i] = 32'(i) * 32'h9E3779B1;
    #23 rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(busy == 0 && mem_en == 0 && ld_valid == 0, "R10 reset controls", {busy, mem_en, ld_valid}, 0);
    chk(ld_data == 0, "R10 reset ld_data", ld_data, 0);

    // R10 reset offset is zero: auto full-word lands on the base; R7 word format
    old = mem[100];
    run_op(3'd5, 16'hBEEF, 16'd100, 13'd0, 2'd2, 1'b0, 11'h123, 0);
    chk(mem[100] == {11'h123, 3'b000, 2'd2, 16'hBEEF}, "R10 R7 auto word at reset offset", mem[100],
        {11'h123, 3'b000, 2'd2, 16'hBEEF});

    // R1 R2 R3 R9 half store sweep
    for (int i = 0; i < 300; i++) begin
      b = 16'(i * 1237 + 5);
      ofs = 13'((i * 53) % 2048) | 13'((i & 3) << 11);
      so = int'(ofs[10:0]); if (so >= 1024) so -= 2048;
      ea = eaddr(b, so);
      d = 16'(i * 40503 + 7);
      old = mem[ea];
      run_op(3'(i & 1), d, b, ofs, 2'(i >> 2), i[1], 11'd0, 0);
      expw = old;
      if (i & 1) expw[31:16] = hv(d, 2'(i >> 2), i[1]);
      else       expw[15:0]  = hv(d, 2'(i >> 2), i[1]);
      chk(last_addr == ea, "R1 store address", last_addr, ea);
      chk(mem[ea] == expw, "R2 R3 half store word", mem[ea], expw);
      chk(last_cycles == 4 && last_strobes == 1, "R9 store timing",
          {last_cycles, last_strobes}, {32'd4, 32'd1});
    end

    // R1 R8 load sweep
    for (int i = 0; i < 200; i++) begin
      b = 16'(i * 911 + 3);
      ofs = 13'((i * 131) % 8192);
      so = int'(ofs); if (so >= 4096) so -= 8192;
      ea = eaddr(b, so);
      run_op(3'(6 + (i & 1)), 16'd0, b, ofs, 2'd0, 1'b0, 11'd0, 0);
      chk(last_addr == ea, "R1 load address", last_addr, ea);
      chk(ld_data == ((i & 1) ? mem[ea][31:16] : mem[ea][15:0]), "R8 load data", ld_data,
          (i & 1) ? mem[ea][31:16] : mem[ea][15:0]);
      chk(last_lv == 1 && last_cycles == 4, "R8 ld_valid single pulse", last_lv, 1);
    end

    // R1 wrap above and below
    run_op(3'd0, 16'h1357, 16'd2047, 13'd4, 2'd0, 1'b0, 11'd0, 0);
    chk(last_addr == 0 && mem[0][15:0] == 16'h1357, "R1 wrap up", last_addr, 0);
    run_op(3'd6, 16'd0, 16'd0, 13'h1FFC, 2'd0, 1'b0, 11'd0, 0);
    chk(last_addr == 2047 && ld_data == mem[2047][15:0], "R1 wrap down", last_addr, 2047);

    // R4 full word ignores label_en
    run_op(3'd2, 16'hC0DE, 16'd700, 13'd8, 2'd3, 1'b1, 11'h5A5, 0);
    chk(mem[702] == {11'h5A5, 3'b000, 2'd3, 16'hC0DE}, "R4 full word", mem[702],
        {11'h5A5, 3'b000, 2'd3, 16'hC0DE});

    // R5 set-offset, no strobe
    run_op(3'd3, 16'd0, 16'd0, 13'd16, 2'd0, 1'b0, 11'd0, 0);
    chk(last_strobes == 0 && last_cycles == 4, "R5 no access", last_strobes, 0);
    // R6 low, high, next word
    old = mem[205];
    run_op(3'd4, 16'h1111, 16'd200, 13'd0, 2'd0, 1'b0, 11'd0, 0);
    chk(last_addr == 204 && mem[204][15:0] == 16'h1111, "R6 first low", mem[204], 16'h1111);
    run_op(3'd4, 16'h2222, 16'd200, 13'd0, 2'd1, 1'b1, 11'd0, 0);
    chk(mem[204] == {16'h6222, 16'h1111}, "R6 then high same word", mem[204], {16'h6222, 16'h1111});
    run_op(3'd4, 16'h3333, 16'd200, 13'd0, 2'd0, 1'b0, 11'd0, 0);
    chk(mem[205] == {old[31:16], 16'h3333}, "R6 advance to next word", mem[205], {old[31:16], 16'h3333});
    // R5 set-offset mid-pair clears phase; negative offset
    run_op(3'd3, 16'd0, 16'd0, 13'h7F8, 2'd0, 1'b0, 11'd0, 0);
    old = mem[198];
    run_op(3'd4, 16'h4444, 16'd200, 13'd0, 2'd0, 1'b0, 11'd0, 0);
    chk(mem[198] == {old[31:16], 16'h4444}, "R5 negative offset and phase cleared", mem[198],
        {old[31:16], 16'h4444});
    // R7 auto word advances and clears phase
    run_op(3'd5, 16'h5555, 16'd200, 13'd0, 2'd0, 1'b0, 11'h001, 0);
    chk(last_addr == 198 && mem[198] == {11'h001, 5'd0, 16'h5555}, "R7 auto word", mem[198],
        {11'h001, 5'd0, 16'h5555});
    run_op(3'd5, 16'h6666, 16'd200, 13'd0, 2'd1, 1'b0, 11'h002, 0);
    chk(last_addr == 199, "R7 auto word advance", last_addr, 199);
    old = mem[200];
    run_op(3'd4, 16'h7777, 16'd200, 13'd0, 2'd0, 1'b0, 11'd0, 0);
    chk(mem[200] == {old[31:16], 16'h7777}, "R7 phase cleared by auto word", mem[200],
        {old[31:16], 16'h7777});

    // R9 request while busy is ignored
    mem[500] = 32'hA5A5A5A5;
    run_op(3'd0, 16'h0F0F, 16'd600, 13'd0, 2'd0, 1'b0, 11'd0, 1);
    repeat (6) @(negedge clk);
    chk(mem[500] == 32'hA5A5A5A5 && last_strobes == 1, "R9 busy request ignored", mem[500], 32'hA5A5A5A5);
    chk(busy == 0, "R9 idle after ignored request", busy, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule